// File: doc/BRIEF.md
# Timer Channel Byte Access Sequencer

This block is the host-facing register front end for a single channel of a three-channel interval timer. The host bus is one byte wide, but the channel's count is sixteen bits wide. The block turns byte-wide bus traffic into whole 16-bit load operations. It also delivers the running count to the host one byte at a time. The counter core sits beside it and supplies the live count. The core consumes the load value, the load strobe, the counting mode and the decimal-counting flag. The block does no counting itself.

A control write carries a 2-bit channel number. Only the instance whose channel parameter matches that number acts on the write. The write either programs a byte access order or takes a snapshot of the live count. The three byte orders are: low byte only, high byte only, and low byte followed by high byte. A snapshot is frozen when taken and reads back low byte first, then high byte. After that, reads fall back to the live count.

Three such instances share one bus, one per channel address, with the control word at the highest address.

Top module: `tmr_access_seq`

## Requirements
- R1: After a synchronous reset, `rd_data` is 0x00, `load_pulse` is low, `load_value` is 0x0000, `mode_q` is 0 and `bcd_q` is 0. The access order is low-then-high, and both byte phases point at the low byte.
- R2: A write to address 3 programs this channel when bits 7:6 equal `CHAN_ID` and bits 5:4 are nonzero. Bits 3:1 go to `mode_q` and bit 0 goes to `bcd_q`. Bits 5:4 become the access order: 1 is low only, 2 is high only, 3 is low then high. Programming returns both byte phases to the low byte and discards any pending snapshot. A control write whose bits 7:6 name another channel changes nothing.
- R3: With access order 1, a data write to address `CHAN_ID` raises `load_pulse` for exactly the next cycle, with `load_value` = {0x00, byte}.
- R4: With access order 2, a data write raises `load_pulse` for the next cycle, with `load_value` = {byte, 0x00}.
- R5: With access order 3, the first data write only holds the byte and gives no pulse. The second gives a pulse with `load_value` = {second, first}. The write phase then returns to the low byte.
- R6: A read of address `CHAN_ID` with no pending snapshot returns a byte of the `live_count` sampled in the read cycle, on `rd_data` the next cycle. Order 1 returns the low byte and order 2 the high byte. Order 3 alternates, low first.
- R7: A control write with bits 7:6 equal to `CHAN_ID` and bits 5:4 = 0 copies `live_count` into a snapshot. The next two reads return its low byte and then its high byte, whatever the live count does meanwhile. The mode, flag and access order are unchanged.
- R8: After the second snapshot byte is read, reads return the live count again. Snapshot reads do not advance the live read phase.
- R9: A snapshot command issued while a snapshot is still unread is ignored. The first snapshot is the one read out.
- R10: A read of any address other than `CHAN_ID` puts 0x00 on `rd_data` and changes no state. Data writes to other channel addresses cause no pulse and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address: channels 0 to 2, control word at 3 |
| bus_wdata | input | 8 | Write data byte |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| live_count | input | 16 | Running count from the counter core |
| rd_data | output | 8 | Registered read byte, valid the cycle after the strobe |
| load_value | output | 16 | Assembled count to load, held between loads |
| load_pulse | output | 1 | One-cycle load strobe |
| mode_q | output | 3 | Programmed counting mode |
| bcd_q | output | 1 | Programmed decimal-counting flag |

## Verification
The bench runs the instance as channel 1, so that a channel match is never simply a match on zero. It drives a `live_count` that moves every cycle. A design that fetched snapshot bytes from the live count, rather than from the frozen copy, would then return wrong high bytes.

Word-order writes are cut short by reprogramming partway through. A design that kept the write phase would load a value assembled from a stale low byte.

A snapshot is taken between two live word reads. A design that let snapshot reads disturb the live phase would return the low byte where the high byte is due.

A second snapshot command is issued over a pending one. A design that accepted it would read out a later count. Foreign control words, foreign addresses and reads of the control address are all mixed in, and each must leave every output exactly as a reference model predicts.

// File: rtl/tmr_access_pkg.sv
package tmr_access_pkg;

  typedef enum logic [1:0] {
    ACC_SNAP = 2'd0,
    ACC_LO   = 2'd1,
    ACC_HI   = 2'd2,
    ACC_WORD = 2'd3
  } acc_e;

  localparam int SEL_HI  = 7;
  localparam int SEL_LO  = 6;
  localparam int ACC_MSB = 5;
  localparam int ACC_LSB = 4;
  localparam int MODE_MSB = 3;
  localparam int MODE_LSB = 1;
  localparam int BCD_BIT = 0;
  localparam int MODE_W  = MODE_MSB - MODE_LSB + 1;

endpackage

// File: rtl/tmr_ctrl_decode.sv
module tmr_ctrl_decode
  import tmr_access_pkg::*;
#(
  parameter int CHAN_ID = 0,
  parameter int BYTE_W  = 8,
  parameter int ADDR_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  input  logic              bus_wr,
  output logic [MODE_W-1:0] mode_q,
  output logic              bcd_q,
  output acc_e              acc_q,
  output logic              prog_evt,
  output logic              latch_evt
);

  localparam logic [ADDR_W-1:0] CTRL_ADDR = {ADDR_W{1'b1}};
  localparam logic [1:0]        MY_SEL    = 2'(CHAN_ID);

  logic ctrl_wr;
  logic sel_match;
  acc_e acc_field;

  assign ctrl_wr   = bus_wr && (bus_addr == CTRL_ADDR);
  assign sel_match = (bus_wdata[SEL_HI:SEL_LO] == MY_SEL);
  assign acc_field = acc_e'(bus_wdata[ACC_MSB:ACC_LSB]);
  assign prog_evt  = ctrl_wr && sel_match && (acc_field != ACC_SNAP);
  assign latch_evt = ctrl_wr && sel_match && (acc_field == ACC_SNAP);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      bcd_q  <= 1'b0;
      acc_q  <= ACC_WORD;
    end else if (prog_evt) begin
      mode_q <= bus_wdata[MODE_MSB:MODE_LSB];
      bcd_q  <= bus_wdata[BCD_BIT];
      acc_q  <= acc_field;
    end
  end

  // R2 / R7: fields move only on a matching programming write
  p_fields_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !prog_evt |=> ($stable(mode_q) && $stable(bcd_q) && $stable(acc_q)));

  p_fields_capture_r2: assert property (@(posedge clk) disable iff (rst)
    prog_evt |=> (mode_q == $past(bus_wdata[MODE_MSB:MODE_LSB])) &&
                 (bcd_q == $past(bus_wdata[BCD_BIT])));

endmodule

// File: rtl/tmr_wr_path.sv
module tmr_wr_path
  import tmr_access_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_hit,
  input  logic [BYTE_W-1:0]   bus_wdata,
  input  acc_e                acc_q,
  input  logic                prog_evt,
  output logic [2*BYTE_W-1:0] load_value,
  output logic                load_pulse
);

  localparam int CNT_W = 2 * BYTE_W;

  logic              wr_phase;
  logic [BYTE_W-1:0] lo_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_phase   <= 1'b0;
      lo_hold    <= '0;
      load_value <= '0;
      load_pulse <= 1'b0;
    end else begin
      load_pulse <= 1'b0;
      if (prog_evt) begin
        wr_phase <= 1'b0;
      end else if (wr_hit) begin
        unique case (acc_q)
          ACC_LO: begin
            load_value <= {{BYTE_W{1'b0}}, bus_wdata};
            load_pulse <= 1'b1;
          end
          ACC_HI: begin
            load_value <= {bus_wdata, {BYTE_W{1'b0}}};
            load_pulse <= 1'b1;
          end
          ACC_WORD: begin
            if (!wr_phase) begin
              lo_hold  <= bus_wdata;
              wr_phase <= 1'b1;
            end else begin
              load_value <= {bus_wdata, lo_hold};
              load_pulse <= 1'b1;
              wr_phase   <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  p_no_write_no_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    !wr_hit |=> !load_pulse);

  p_lsb_load_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && acc_q == ACC_LO) |=>
      (load_pulse && load_value == CNT_W'($past(bus_wdata))));

  p_msb_load_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && acc_q == ACC_HI) |=>
      (load_pulse && load_value[BYTE_W-1:0] == '0 &&
       load_value[CNT_W-1:BYTE_W] == $past(bus_wdata)));

  p_word_first_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && acc_q == ACC_WORD && !wr_phase) |=>
      (!load_pulse && $stable(load_value)));

endmodule

// File: rtl/tmr_rd_path.sv
module tmr_rd_path
  import tmr_access_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_hit,
  input  logic                rd_other,
  input  logic                latch_evt,
  input  logic                prog_evt,
  input  acc_e                acc_q,
  input  logic [2*BYTE_W-1:0] live_count,
  output logic [BYTE_W-1:0]   rd_data
);

  localparam int CNT_W = 2 * BYTE_W;

  logic [CNT_W-1:0]  snap_q;
  logic              snap_valid;
  logic              snap_phase;
  logic              live_phase;
  logic [BYTE_W-1:0] live_lo, live_hi, snap_lo, snap_hi;

  assign live_lo = live_count[BYTE_W-1:0];
  assign live_hi = live_count[CNT_W-1:BYTE_W];
  assign snap_lo = snap_q[BYTE_W-1:0];
  assign snap_hi = snap_q[CNT_W-1:BYTE_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_q     <= '0;
      snap_valid <= 1'b0;
      snap_phase <= 1'b0;
      live_phase <= 1'b0;
      rd_data    <= '0;
    end else begin
      if (prog_evt) begin
        live_phase <= 1'b0;
        snap_valid <= 1'b0;
        snap_phase <= 1'b0;
      end else if (latch_evt && !snap_valid) begin
        snap_q     <= live_count;
        snap_valid <= 1'b1;
        snap_phase <= 1'b0;
      end

      if (rd_hit) begin
        if (snap_valid) begin
          rd_data    <= snap_phase ? snap_hi : snap_lo;
          snap_phase <= !snap_phase;
          if (snap_phase) snap_valid <= 1'b0;
        end else begin
          unique case (acc_q)
            ACC_LO:  rd_data <= live_lo;
            ACC_HI:  rd_data <= live_hi;
            default: begin
              rd_data    <= live_phase ? live_hi : live_lo;
              live_phase <= !live_phase;
            end
          endcase
        end
      end else if (rd_other) begin
        rd_data <= '0;
      end
    end
  end

  p_second_snap_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (latch_evt && snap_valid && !rd_hit) |=> $stable(snap_q) && snap_valid);

  p_foreign_read_zero_r10: assert property (@(posedge clk) disable iff (rst)
    rd_other |=> (rd_data == '0));

  p_snap_read_keeps_phase_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && snap_valid && !prog_evt) |=> $stable(live_phase));

  p_idle_holds_data_r6: assert property (@(posedge clk) disable iff (rst)
    (!rd_hit && !rd_other) |=> $stable(rd_data));

endmodule

// File: rtl/tmr_access_seq.sv
module tmr_access_seq
  import tmr_access_pkg::*;
#(
  parameter int CHAN_ID = 0,
  parameter int BYTE_W  = 8,
  parameter int ADDR_W  = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [BYTE_W-1:0]   bus_wdata,
  input  logic                bus_rd,
  input  logic                bus_wr,
  input  logic [2*BYTE_W-1:0] live_count,
  output logic [BYTE_W-1:0]   rd_data,
  output logic [2*BYTE_W-1:0] load_value,
  output logic                load_pulse,
  output logic [MODE_W-1:0]   mode_q,
  output logic                bcd_q
);

  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(CHAN_ID);

  logic rd_hit, rd_other, wr_hit;
  logic prog_evt, latch_evt;
  acc_e acc_q;

  assign rd_hit   = bus_rd && (bus_addr == MY_ADDR);
  assign rd_other = bus_rd && (bus_addr != MY_ADDR);
  assign wr_hit   = bus_wr && (bus_addr == MY_ADDR);

  tmr_ctrl_decode #(.CHAN_ID(CHAN_ID), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .mode_q(mode_q), .bcd_q(bcd_q), .acc_q(acc_q),
    .prog_evt(prog_evt), .latch_evt(latch_evt)
  );

  tmr_wr_path #(.BYTE_W(BYTE_W)) u_wr (
    .clk(clk), .rst(rst), .wr_hit(wr_hit), .bus_wdata(bus_wdata),
    .acc_q(acc_q), .prog_evt(prog_evt), .load_value(load_value),
    .load_pulse(load_pulse)
  );

  tmr_rd_path #(.BYTE_W(BYTE_W)) u_rd (
    .clk(clk), .rst(rst), .rd_hit(rd_hit), .rd_other(rd_other),
    .latch_evt(latch_evt), .prog_evt(prog_evt), .acc_q(acc_q),
    .live_count(live_count), .rd_data(rd_data)
  );

  // R1: outputs quiet in the first cycle after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!load_pulse && rd_data == '0 && mode_q == '0 && !bcd_q));

endmodule

// File: tb/tmr_access_seq_test.sv
module tmr_access_seq_test;

  localparam int CH = 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [15:0] live_count = 16'hA5C3;
  logic [7:0]  rd_data;
  logic [15:0] load_value;
  logic        load_pulse;
  logic [2:0]  mode_q;
  logic        bcd_q;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  tmr_access_seq #(.CHAN_ID(CH)) uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .live_count(live_count),
    .rd_data(rd_data), .load_value(load_value), .load_pulse(load_pulse),
    .mode_q(mode_q), .bcd_q(bcd_q)
  );

  // reference model state
  int m_mode, m_bcd, m_acc, m_wph, m_rph, m_sv, m_sph, m_snap;
  int m_rd, m_lp, m_lval, m_hold;

  always @(posedge clk) begin
    live_count <= #2 live_count - 16'd293;
  end

  always @(posedge clk) begin
    int w, a;
    cycles++;
    if (rst) begin
      m_mode = 0; m_bcd = 0; m_acc = 3; m_wph = 0; m_rph = 0;
      m_sv = 0; m_sph = 0; m_snap = 0; m_rd = 0; m_lp = 0;
      m_lval = 0; m_hold = 0;
    end else begin
      w = bus_wdata;
      a = bus_addr;
      m_lp = 0;
      if (bus_wr && a == 3 && (w >> 6) == CH) begin
        if (((w >> 4) & 3) == 0) begin
          if (m_sv == 0) begin m_snap = live_count; m_sv = 1; m_sph = 0; end
        end else begin
          m_mode = (w >> 1) & 7; m_bcd = w & 1; m_acc = (w >> 4) & 3;
          m_wph = 0; m_rph = 0; m_sv = 0; m_sph = 0;
        end
      end else if (bus_wr && a == CH) begin
        if (m_acc == 1) begin m_lval = w; m_lp = 1; end
        else if (m_acc == 2) begin m_lval = w * 256; m_lp = 1; end
        else if (m_wph == 0) begin m_hold = w; m_wph = 1; end
        else begin m_lval = w * 256 + m_hold; m_lp = 1; m_wph = 0; end
      end
      if (bus_rd) begin
        if (a != CH) m_rd = 0;
        else if (m_sv != 0) begin
          m_rd = (m_sph != 0) ? (m_snap / 256) : (m_snap % 256);
          if (m_sph != 0) m_sv = 0;
          m_sph = 1 - m_sph;
        end else if (m_acc == 1) m_rd = live_count % 256;
        else if (m_acc == 2) m_rd = live_count / 256;
        else begin
          m_rd = (m_rph != 0) ? (live_count / 256) : (live_count % 256);
          m_rph = 1 - m_rph;
        end
      end
    end
  end

  task automatic cmp(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: %s actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && cycles > 0) begin
      cmp("rd_data", int'(rd_data), m_rd);
      cmp("load_pulse", int'(load_pulse), m_lp);
      cmp("load_value", int'(load_value), m_lval);
      cmp("mode_q", int'(mode_q), m_mode);
      cmp("bcd_q", int'(bcd_q), m_bcd);
    end
  end

  task automatic op(input bit w, input bit r, input logic [1:0] a, input logic [7:0] d);
    @(posedge clk);
    #2;
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) op(1'b0, 1'b0, 2'd0, 8'h00);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    op(1'b1, 1'b0, a, d);
    idle(1);
  endtask

  task automatic rd(input logic [1:0] a);
    op(1'b0, 1'b1, a, 8'h00);
    idle(1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    // R1: explicit reset-state check before any traffic
    @(negedge clk);
    cmp("R1 reset rd_data", int'(rd_data), 0);
    cmp("R1 reset mode", int'(mode_q), 0);
    idle(2);

    cur_req = "R6"; // default word order after reset
    repeat (4) rd(2'(CH));

    cur_req = "R2";
    wr(2'd3, 8'h74);          // ch1, word, mode 2
    wr(2'd3, 8'hB2);          // ch2, must be ignored
    wr(2'd3, 8'h53);          // ch1, low only, mode 1, bcd
    wr(2'd3, 8'h80);          // ch2 snapshot, ignored

    cur_req = "R3";
    wr(2'(CH), 8'h5A);
    op(1'b1, 1'b0, 2'(CH), 8'hFF);   // back-to-back writes
    op(1'b1, 1'b0, 2'(CH), 8'h01);
    idle(1);
    cur_req = "R6";
    rd(2'(CH)); rd(2'(CH));

    cur_req = "R4";
    wr(2'd3, 8'h64);
    wr(2'(CH), 8'h12);
    wr(2'(CH), 8'hE7);
    cur_req = "R6";
    rd(2'(CH)); rd(2'(CH));

    cur_req = "R5";
    wr(2'd3, 8'h7A);
    wr(2'(CH), 8'h34);
    wr(2'(CH), 8'h12);
    wr(2'(CH), 8'hCD);        // half word, then reprogram
    wr(2'd3, 8'h76);
    wr(2'(CH), 8'h01);
    wr(2'(CH), 8'h02);

    cur_req = "R6";
    repeat (5) rd(2'(CH));

    cur_req = "R7";
    wr(2'd3, 8'h74);
    wr(2'd3, 8'h40);
    idle(3);
    rd(2'(CH)); idle(2); rd(2'(CH));
    cur_req = "R8";
    rd(2'(CH)); rd(2'(CH));

    cur_req = "R8";           // snapshot between live low and live high
    rd(2'(CH));
    wr(2'd3, 8'h40);
    rd(2'(CH)); rd(2'(CH)); rd(2'(CH));

    cur_req = "R9";
    wr(2'd3, 8'h40);
    idle(4);
    wr(2'd3, 8'h40);
    rd(2'(CH)); rd(2'(CH)); rd(2'(CH));

    cur_req = "R2";           // reprogram discards pending snapshot
    wr(2'd3, 8'h40);
    wr(2'd3, 8'h56);
    rd(2'(CH)); rd(2'(CH));

    cur_req = "R10";
    rd(2'(CH));
    rd(2'd3);
    rd(2'(CH));
    rd(2'd0);
    wr(2'd2, 8'h99);
    wr(2'd0, 8'h77);
    rd(2'd2);
    wr(2'(CH), 8'h3C);
    idle(3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule